// File: doc/BRIEF.md
# Indirect Memory Permission Checker

This block decides whether a memory access may proceed when a translation descriptor does not hold its permissions directly. The descriptor carries two 4-bit indices instead. One picks a 4-bit code from a programmable base table, the other from a programmable overlay table. The base code decodes to read, write and execute rights, plus a guarded-stack right. It also decodes to a flag that says whether the overlay applies. When the flag is set, the overlay rights are ANDed with the base rights, so the overlay can only take rights away.

Software loads each table as one 64-bit word through a configuration write port. A request carries the two indices and an access type. One cycle later the block answers with a fault bit, the effective rights and the guarded-stack right. It also returns the decoded base rights on a separate output, so a translation cache can keep them apart from the overlay result. Every request reads the overlay table as it stands, so an overlay rewrite needs no invalidation step.

Top module: `perm_check`

## Requirements
- R1: Each table holds 16 slots of 4 bits, and slot n sits in bits [4n+3:4n]. A write with `cfg_wr_sel`=0 loads the base table and a write with `cfg_wr_sel`=1 loads the overlay table.
- R2: Base codes 0000 (none), 0001 (R), 0010 (X), 0011 (RX), 0101 (RW), 0110 (RWX) and 0111 (RWX) set the overlay flag.
- R3: Base codes 1000 (R), 1010 (RX), 1100 (RW) and 1110 (RWX) clear the overlay flag, so the effective rights equal the base rights whatever the overlay slot holds.
- R4: Base code 1001 gives read plus the guarded-stack right, and it clears the overlay flag. `rsp_gcs` is 1 only for this code. Access type 3 (guarded-stack) is allowed only when `rsp_gcs` is 1.
- R5: Reserved base codes 0100, 1011, 1101 and 1111 decode as no access. Code 0100 keeps the overlay flag.
- R6: When the overlay flag is set, the effective rights are the bitwise AND of the base rights and the overlay rights. Overlay code bit 0 gives read, bit 1 gives execute and bit 2 gives write.
- R7: Overlay code 0000, and any overlay code with bit 3 set, decodes as no rights.
- R8: Access type 0 is read, 1 is write, 2 is execute and 3 is guarded-stack. `rsp_fault` is 1 when the effective rights lack the right that the access type needs. Worked case: base slot 3 holds 0101 and overlay slot 6 holds 0001. A request with indices 3 and 6 then allows reads and faults writes and executes.
- R9: A request with `req_valid`=1 gives `rsp_valid`=1 exactly one cycle later. In a cycle with no response, `rsp_valid`, `rsp_fault`, `rsp_perm`, `rsp_gcs` and `rsp_base_perm` are all 0.
- R10: `rsp_base_perm` carries the decoded base rights (bit 0 read, bit 1 write, bit 2 execute) and does not depend on the overlay. `rsp_perm` uses the same bit order.
- R11: A table write in the same cycle as a request does not affect that request, and it does affect the next request. Overlay writes need no other action.
- R12: After reset both tables are all zeros, so every access faults with no rights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Table write strobe |
| cfg_wr_sel | input | 1 | 0 = base table, 1 = overlay table |
| cfg_wr_data | input | 64 | Whole-table write value |
| req_valid | input | 1 | Request present |
| req_base_idx | input | 4 | Base table slot index |
| req_ovl_idx | input | 4 | Overlay table slot index |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 guarded-stack |
| rsp_valid | output | 1 | Response present, one cycle after request |
| rsp_fault | output | 1 | Access denied |
| rsp_perm | output | 3 | Effective rights {X,W,R} |
| rsp_gcs | output | 1 | Guarded-stack right granted |
| rsp_base_perm | output | 3 | Decoded base rights {X,W,R} |

## Verification
The hardest case to reach is a table write that lands in the same cycle as a request. The answer must then show the old table, and the next request must show the new one. The bench drives both strobes on the same falling edge and sends a follow-up request. It does this for the base table and for the overlay table. The bench also loads an identity pattern, where each slot holds its own index. With that pattern, sweeping the two indices covers every pair of base and overlay codes with every access type, without any rewrites. A scrambled pattern then checks the slot positions on their own.

// File: rtl/perm_pkg.sv
package perm_pkg;

    localparam int CODE_W = 4;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } rights_t;

    typedef struct packed {
        rights_t rights;
        logic    gcs;
        logic    ovl_on;
    } base_dec_t;

    typedef enum logic [1:0] {
        ACC_READ   = 2'd0,
        ACC_WRITE  = 2'd1,
        ACC_EXEC   = 2'd2,
        ACC_GSTACK = 2'd3
    } acc_e;

    localparam rights_t NO_RIGHTS = '{x: 1'b0, w: 1'b0, r: 1'b0};

    function automatic base_dec_t decode_base(input logic [CODE_W-1:0] code);
        base_dec_t d;
        d.rights = NO_RIGHTS;
        d.gcs    = 1'b0;
        d.ovl_on = ~code[3];
        unique case (code)
            4'b0001, 4'b1000: d.rights.r = 1'b1;
            4'b0010:          d.rights.x = 1'b1;
            4'b0011, 4'b1010: begin d.rights.r = 1'b1; d.rights.x = 1'b1; end
            4'b0101, 4'b1100: begin d.rights.r = 1'b1; d.rights.w = 1'b1; end
            4'b0110, 4'b0111, 4'b1110: d.rights = '{x: 1'b1, w: 1'b1, r: 1'b1};
            4'b1001:          begin d.rights.r = 1'b1; d.gcs = 1'b1; end
            default:          d.rights = NO_RIGHTS;
        endcase
        return d;
    endfunction

    function automatic rights_t decode_overlay(input logic [CODE_W-1:0] code);
        rights_t o;
        if (code[3]) begin
            o = NO_RIGHTS;
        end else begin
            o.r = code[0];
            o.x = code[1];
            o.w = code[2];
        end
        return o;
    endfunction

    function automatic logic access_ok(input rights_t eff, input logic gcs, input acc_e acc);
        logic ok;
        unique case (acc)
            ACC_READ:   ok = eff.r;
            ACC_WRITE:  ok = eff.w;
            ACC_EXEC:   ok = eff.x;
            default:    ok = gcs;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/perm_regfile.sv
module perm_regfile #(
    parameter int SLOTS  = 16,
    parameter int SLOT_W = 4,
    localparam int REG_W = SLOTS * SLOT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] table_q
);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                table_q[s*SLOT_W +: SLOT_W] <= '0;
            end else if (wr_en) begin
                table_q[s*SLOT_W +: SLOT_W] <= wr_data[s*SLOT_W +: SLOT_W];
            end
        end
    end

endmodule

// File: rtl/perm_lookup.sv
module perm_lookup
    import perm_pkg::*;
#(
    parameter int SLOTS     = 16,
    parameter bit BASE_SIDE = 1'b1,
    localparam int REG_W = SLOTS * CODE_W,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic [REG_W-1:0] table_q,
    input  logic [IDX_W-1:0] idx,
    output rights_t          rights,
    output logic             gcs,
    output logic             ovl_on
);

    logic [CODE_W-1:0] code;

    always_comb begin
        code = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (idx == IDX_W'(s)) code = table_q[s*CODE_W +: CODE_W];
        end
    end

    if (BASE_SIDE) begin : g_base
        base_dec_t dec;
        always_comb begin
            dec    = decode_base(code);
            rights = dec.rights;
            gcs    = dec.gcs;
            ovl_on = dec.ovl_on;
        end
    end else begin : g_ovl
        always_comb begin
            rights = decode_overlay(code);
            gcs    = 1'b0;
            ovl_on = 1'b0;
        end
    end

endmodule

// File: rtl/perm_check.sv
module perm_check
    import perm_pkg::*;
#(
    parameter int SLOTS = 16,
    localparam int REG_W = SLOTS * CODE_W,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr_en,
    input  logic             cfg_wr_sel,
    input  logic [REG_W-1:0] cfg_wr_data,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_base_idx,
    input  logic [IDX_W-1:0] req_ovl_idx,
    input  logic [1:0]       req_acc,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [2:0]       rsp_perm,
    output logic             rsp_gcs,
    output logic [2:0]       rsp_base_perm
);

    logic [REG_W-1:0] base_tab, ovl_tab;
    rights_t base_r, ovl_r, eff_r;
    logic    base_gcs, base_ovl_on;
    logic    ovl_gcs_unused, ovl_on_unused;
    logic    ok;

    perm_regfile #(.SLOTS(SLOTS), .SLOT_W(CODE_W)) u_base_tab (
        .clk(clk), .rst(rst),
        .wr_en(cfg_wr_en & ~cfg_wr_sel),
        .wr_data(cfg_wr_data),
        .table_q(base_tab)
    );

    perm_regfile #(.SLOTS(SLOTS), .SLOT_W(CODE_W)) u_ovl_tab (
        .clk(clk), .rst(rst),
        .wr_en(cfg_wr_en & cfg_wr_sel),
        .wr_data(cfg_wr_data),
        .table_q(ovl_tab)
    );

    perm_lookup #(.SLOTS(SLOTS), .BASE_SIDE(1'b1)) u_base_lk (
        .table_q(base_tab), .idx(req_base_idx),
        .rights(base_r), .gcs(base_gcs), .ovl_on(base_ovl_on)
    );

    perm_lookup #(.SLOTS(SLOTS), .BASE_SIDE(1'b0)) u_ovl_lk (
        .table_q(ovl_tab), .idx(req_ovl_idx),
        .rights(ovl_r), .gcs(ovl_gcs_unused), .ovl_on(ovl_on_unused)
    );

    always_comb begin
        eff_r = base_ovl_on ? (base_r & ovl_r) : base_r;
        ok    = access_ok(eff_r, base_gcs, acc_e'(req_acc));
    end

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            rsp_valid     <= 1'b0;
            rsp_fault     <= 1'b0;
            rsp_perm      <= '0;
            rsp_gcs       <= 1'b0;
            rsp_base_perm <= '0;
        end else begin
            rsp_valid     <= 1'b1;
            rsp_fault     <= ~ok;
            rsp_perm      <= eff_r;
            rsp_gcs       <= base_gcs;
            rsp_base_perm <= base_r;
        end
    end

endmodule

// File: rtl/perm_check_sva.sv
module perm_check_sva (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       rsp_valid,
    input logic       rsp_fault,
    input logic [2:0] rsp_perm,
    input logic       rsp_gcs,
    input logic [2:0] rsp_base_perm
);

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R9

    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (rsp_perm == 3'b000 && !rsp_fault && !rsp_gcs && rsp_base_perm == 3'b000)); // R9

    AST_OVL_NEVER_ADDS: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ((rsp_perm & ~rsp_base_perm) == 3'b000)); // R6

    AST_NO_RIGHTS_FAULT: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_perm == 3'b000 && !rsp_gcs) |-> rsp_fault); // R8

    AST_GCS_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        rsp_gcs |-> (rsp_perm == 3'b001 && rsp_base_perm == 3'b001)); // R4

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rsp_valid); // R12

endmodule

bind perm_check perm_check_sva u_sva (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_perm(rsp_perm),
    .rsp_gcs(rsp_gcs), .rsp_base_perm(rsp_base_perm)
);

// File: tb/tb_perm_check.sv
`timescale 1ns/1ps
module tb_perm_check;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr_en, cfg_wr_sel;
    logic [63:0] cfg_wr_data;
    logic        req_valid;
    logic [3:0]  req_base_idx, req_ovl_idx;
    logic [1:0]  req_acc;
    logic        rsp_valid, rsp_fault, rsp_gcs;
    logic [2:0]  rsp_perm, rsp_base_perm;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    perm_check dut (
        .clk(clk), .rst(rst),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
        .req_valid(req_valid), .req_base_idx(req_base_idx), .req_ovl_idx(req_ovl_idx),
        .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_perm(rsp_perm),
        .rsp_gcs(rsp_gcs), .rsp_base_perm(rsp_base_perm)
    );

    // expected base rights {x,w,r} and gcs/overlay flags, from R2..R5
    function automatic logic [4:0] model_base(input logic [3:0] c);
        // returns {ovl_on, gcs, x, w, r}
        case (c)
            4'b0000: return 5'b1_0_000;
            4'b0001: return 5'b1_0_001;
            4'b0010: return 5'b1_0_100;
            4'b0011: return 5'b1_0_101;
            4'b0100: return 5'b1_0_000;
            4'b0101: return 5'b1_0_011;
            4'b0110: return 5'b1_0_111;
            4'b0111: return 5'b1_0_111;
            4'b1000: return 5'b0_0_001;
            4'b1001: return 5'b0_1_001;
            4'b1010: return 5'b0_0_101;
            4'b1100: return 5'b0_0_011;
            4'b1110: return 5'b0_0_111;
            default: return 5'b0_0_000;
        endcase
    endfunction

    function automatic logic [2:0] model_ovl(input logic [3:0] c);
        if (c[3]) return 3'b000;
        return {c[1], c[2], c[0]};
    endfunction

    function automatic string tag_for(input logic [3:0] b);
        if (b == 4'b1001) return "R4";
        if (b == 4'b0100 || b == 4'b1011 || b == 4'b1101 || b == 4'b1111) return "R5";
        if (b[3]) return "R3";
        return "R6";
    endfunction

    task automatic expect_rsp(input string tag, input logic [3:0] bcode, input logic [3:0] ocode,
                              input logic [1:0] acc);
        logic [4:0] mb;
        logic [2:0] eff, act_need;
        logic       ok;
        mb  = model_base(bcode);
        eff = mb[4] ? (mb[2:0] & model_ovl(ocode)) : mb[2:0];
        case (acc)
            2'd0: ok = eff[0];
            2'd1: ok = eff[1];
            2'd2: ok = eff[2];
            default: ok = mb[3];
        endcase
        act_need = 3'b000;
        checks++;
        if (rsp_valid !== 1'b1 || rsp_fault !== !ok || rsp_perm !== eff ||
            rsp_gcs !== mb[3] || rsp_base_perm !== mb[2:0]) begin
            errors++;
            $display("FAIL %s base=%b ovl=%b acc=%0d: actual v=%b f=%b p=%b g=%b bp=%b expected v=1 f=%b p=%b g=%b bp=%b",
                     tag, bcode, ocode, acc, rsp_valid, rsp_fault, rsp_perm, rsp_gcs,
                     rsp_base_perm, !ok, eff, mb[3], mb[2:0]);
        end
        if (act_need != 3'b000) errors++;
    endtask

    // issue one request, sample response one cycle later at the falling edge
    task automatic send(input logic [3:0] bi, input logic [3:0] oi, input logic [1:0] acc);
        @(negedge clk);
        req_valid = 1'b1; req_base_idx = bi; req_ovl_idx = oi; req_acc = acc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic write_tab(input logic sel, input logic [63:0] val);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = val;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    function automatic logic [3:0] scram(input int n);
        return 4'((n * 7 + 3) % 16);
    endfunction

    logic [63:0] ident, scr;

    initial begin
        rst = 1'b1; cfg_wr_en = 1'b0; cfg_wr_sel = 1'b0; cfg_wr_data = '0;
        req_valid = 1'b0; req_base_idx = '0; req_ovl_idx = '0; req_acc = '0;
        for (int n = 0; n < 16; n++) begin
            ident[4*n +: 4] = 4'(n);
            scr[4*n +: 4]   = scram(n);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R12: reset state
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++; $display("FAIL R12 rsp_valid after reset actual=%b expected=0", rsp_valid);
        end
        for (int a = 0; a < 4; a++) begin
            send(4'(a * 5), 4'(a * 3), 2'(a));
            expect_rsp("R12", 4'b0000, 4'b0000, 2'(a));
        end

        // R9: idle cycle after a response
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0 || rsp_perm !== 3'b000 || rsp_base_perm !== 3'b000) begin
            errors++;
            $display("FAIL R9 idle outputs actual v=%b f=%b p=%b bp=%b expected all 0",
                     rsp_valid, rsp_fault, rsp_perm, rsp_base_perm);
        end

        // R1: identity tables, full sweep of code pairs and access types (R2..R8, R10)
        write_tab(1'b0, ident);
        write_tab(1'b1, ident);
        for (int b = 0; b < 16; b++)
            for (int o = 0; o < 16; o++)
                for (int a = 0; a < 4; a++) begin
                    send(4'(b), 4'(o), 2'(a));
                    expect_rsp(tag_for(4'(b)), 4'(b), 4'(o), 2'(a));
                end

        // R1: scrambled tables check slot placement
        write_tab(1'b0, scr);
        write_tab(1'b1, ~scr);
        for (int b = 0; b < 16; b++)
            for (int o = 0; o < 16; o++) begin
                send(4'(b), 4'(o), 2'(o % 4));
                expect_rsp("R1", scram(b), ~scram(o), 2'(o % 4));
            end

        // R8: worked case, base slot 3 = 0101, overlay slot 6 = 0001
        write_tab(1'b0, 64'h0000_0000_0000_5000);
        write_tab(1'b1, 64'h0000_0000_0100_0000);
        for (int a = 0; a < 3; a++) begin
            send(4'd3, 4'd6, 2'(a));
            expect_rsp("R8", 4'b0101, 4'b0001, 2'(a));
        end
        // R10: base rights unaffected by a different overlay slot (slot 0 = 0000)
        send(4'd3, 4'd0, 2'd0);
        expect_rsp("R10", 4'b0101, 4'b0000, 2'd0);
        // R7: overlay code with bit 3 set removes all rights
        write_tab(1'b1, 64'h0000_0000_0D00_0000);
        send(4'd3, 4'd6, 2'd0);
        expect_rsp("R7", 4'b0101, 4'b1101, 2'd0);

        // R11: overlay write in the same cycle as a request
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = 1'b1; cfg_wr_data = 64'h0000_0000_0700_0000;
        req_valid = 1'b1; req_base_idx = 4'd3; req_ovl_idx = 4'd6; req_acc = 2'd1;
        @(negedge clk);
        cfg_wr_en = 1'b0; req_valid = 1'b0;
        expect_rsp("R11", 4'b0101, 4'b1101, 2'd1);
        send(4'd3, 4'd6, 2'd1);
        expect_rsp("R11", 4'b0101, 4'b0111, 2'd1);

        // R11: base write in the same cycle as a request
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = 1'b0; cfg_wr_data = 64'h0000_0000_0000_9000;
        req_valid = 1'b1; req_base_idx = 4'd3; req_ovl_idx = 4'd6; req_acc = 2'd3;
        @(negedge clk);
        cfg_wr_en = 1'b0; req_valid = 1'b0;
        expect_rsp("R11", 4'b0101, 4'b0111, 2'd3);
        send(4'd3, 4'd6, 2'd3);
        expect_rsp("R4", 4'b1001, 4'b0111, 2'd3);

        // R2: overlay rewrite to read-only leaves a write-capable base code faulting
        write_tab(1'b0, 64'h0000_0000_0000_6000);
        write_tab(1'b1, 64'h0000_0000_0100_0000);
        send(4'd3, 4'd6, 2'd1);
        expect_rsp("R2", 4'b0110, 4'b0001, 2'd1);

        // R12: reset clears the tables again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        send(4'd3, 4'd6, 2'd0);
        expect_rsp("R12", 4'b0000, 4'b0000, 2'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule